// File: doc/BRIEF.md
# Temperature-Indexed DVFS Voltage Selector

This block picks the core-supply code for a device whose safe operating points were measured per design and stored in a calibration table. It runs all the time in normal operation. It reads the die temperature and the clock frequency the system needs. It turns the temperature into a calibrated corner row, rounding upward so the choice stays on the safe side between corners. It then walks the voltage codes of that row from the lowest upward and takes the first code whose stored maximum frequency covers the requirement. The codes span the allowed supply window from 0.85 V (code 0) to 1.35 V (all ones).

A chosen code that differs from the one in force goes to the dc-dc controller as one short serial write. A minimum hold time between two changes stops the supply from chattering when the inputs move quickly. If no code in the row reaches the frequency, or the temperature lies above the hottest calibrated corner, the block requests the highest code and raises an out-of-range flag.

The table itself sits outside the block. The block drives a row and a column and reads back the stored frequency in the same cycle.

Top module: `dvfs_vsel`

## Requirements
- R1: During reset the voltage code is all ones, the out-of-range flag is low, chip select is high and the serial clock is low.
- R2: The table row used is the smallest corner index k for which TEMP_BASE + k*TEMP_STEP is at least the temperature. A temperature exactly on a corner uses that corner's row.
- R3: A temperature above the hottest corner uses the hottest row and raises the out-of-range flag.
- R4: Codes are tried from 0 upward, and the first code whose stored frequency is greater than or equal to the required frequency is chosen. This holds even when the stored frequencies are not monotonic in the code.
- R5: When no code of the row reaches the required frequency, the all-ones code is chosen and the out-of-range flag rises.
- R6: Each change of the voltage code sends one frame. During a frame, chip select is low and VCODE_W bits of the new code go out MSB first on the data line. Each bit is valid at a rising serial-clock edge and stays steady while the serial clock is high.
- R7: No frame is sent while the chosen code equals the code already in force.
- R8: Two consecutive changes of the voltage code are at least HOLD_CYCLES clock cycles apart.
- R9: The out-of-range flag falls again once a later search succeeds at a temperature inside the calibrated range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp | input | TEMP_W | Sensed die temperature code |
| freq_req | input | FREQ_W | Required system clock frequency code |
| tbl_fmax | input | FREQ_W | Stored maximum frequency at the addressed table entry |
| tbl_row | output | CORNER_W | Table row (temperature corner) being read |
| tbl_col | output | VCODE_W | Table column (voltage code) being read |
| vcode | output | VCODE_W | Voltage code currently requested |
| oor | output | 1 | Out-of-range flag from the most recent search |
| spi_sclk | output | 1 | Serial clock to the dc-dc controller |
| spi_cs_n | output | 1 | Active-low chip select of the write frame |
| spi_mosi | output | 1 | Serial data, MSB first |

## Verification
The bench sweeps temperatures just below, exactly on and just above every corner, plus one far beyond the hottest. At each temperature it sweeps the required frequency across its full range, under two tables, one of them non-monotonic.

Each error shows up at a specific point:
- A corner mapping that rounds down, or treats the boundary wrongly, picks a code one row too cool.
- A search that assumes monotonic tables skips the low outlier code.
- A missing saturation leaves a stale code when nothing fits.

Frames are decoded from the pins. Frames sent on an unchanged code, frames with the wrong length, or frames whose content differs from the requested code are all caught. A burst of rapidly toggling demands exposes any change that arrives sooner than the hold time allows.

// File: rtl/dvfs_vsel_pkg.sv
package dvfs_vsel_pkg;

  typedef enum logic {
    SC_LOAD = 1'b0,
    SC_STEP = 1'b1
  } scan_st_e;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_st_e;

endpackage

// File: rtl/dvfs_corner_map.sv
module dvfs_corner_map #(
  parameter int TEMP_W    = 8,
  parameter int N_CORNER  = 4,
  parameter int TEMP_BASE = 25,
  parameter int TEMP_STEP = 20,
  parameter int CORNER_W  = (N_CORNER > 1) ? $clog2(N_CORNER) : 1
) (
  input  logic [TEMP_W-1:0]   temp,
  output logic [CORNER_W-1:0] corner,
  output logic                hot
);

  logic [N_CORNER-1:0] above;
  logic [CORNER_W:0]   cnt;

  // one comparator per calibrated corner
  for (genvar k = 0; k < N_CORNER; k++) begin : g_cmp
    localparam int LIM = TEMP_BASE + TEMP_STEP * k;
    assign above[k] = (32'(temp) > 32'(LIM));
  end

  // corners are ascending, so the count of passed corners is the row
  always_comb begin
    cnt = '0;
    for (int k = 0; k < N_CORNER - 1; k++) begin
      cnt = cnt + {{CORNER_W{1'b0}}, above[k]};
    end
  end

  assign corner = cnt[CORNER_W-1:0];
  assign hot    = above[N_CORNER-1];

endmodule

// File: rtl/dvfs_vscan.sv
module dvfs_vscan
  import dvfs_vsel_pkg::*;
#(
  parameter int CORNER_W = 2,
  parameter int VCODE_W  = 4,
  parameter int FREQ_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CORNER_W-1:0] corner_in,
  input  logic                hot_in,
  input  logic [FREQ_W-1:0]   freq_in,
  output logic [CORNER_W-1:0] tbl_row,
  output logic [VCODE_W-1:0]  tbl_col,
  input  logic [FREQ_W-1:0]   tbl_fmax,
  output logic                res_valid,
  output logic [VCODE_W-1:0]  res_code,
  output logic                res_miss,
  output logic                res_hot
);

  localparam logic [VCODE_W-1:0] CODE_MAX = '1;

  scan_st_e            st_q, st_d;
  logic [CORNER_W-1:0] row_q, row_d;
  logic [VCODE_W-1:0]  col_q, col_d;
  logic [FREQ_W-1:0]   freq_q, freq_d;
  logic                hot_q, hot_d;
  logic                vld_q, vld_d;
  logic [VCODE_W-1:0]  code_q, code_d;
  logic                miss_q, miss_d;
  logic                rhot_q, rhot_d;
  logic                hit, last;

  assign hit  = (tbl_fmax >= freq_q);
  assign last = (col_q == CODE_MAX);

  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    col_d  = col_q;
    freq_d = freq_q;
    hot_d  = hot_q;
    vld_d  = 1'b0;
    code_d = code_q;
    miss_d = miss_q;
    rhot_d = rhot_q;
    case (st_q)
      SC_LOAD: begin
        row_d  = corner_in;
        hot_d  = hot_in;
        freq_d = freq_in;
        col_d  = '0;
        st_d   = SC_STEP;
      end
      default: begin
        if (hit || last) begin
          vld_d  = 1'b1;
          code_d = col_q;
          miss_d = !hit;
          rhot_d = hot_q;
          st_d   = SC_LOAD;
        end else begin
          col_d = col_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_LOAD;
      row_q  <= '0;
      col_q  <= '0;
      freq_q <= '0;
      hot_q  <= 1'b0;
      vld_q  <= 1'b0;
      code_q <= CODE_MAX;
      miss_q <= 1'b0;
      rhot_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      row_q  <= row_d;
      col_q  <= col_d;
      freq_q <= freq_d;
      hot_q  <= hot_d;
      vld_q  <= vld_d;
      code_q <= code_d;
      miss_q <= miss_d;
      rhot_q <= rhot_d;
    end
  end

  assign tbl_row   = row_q;
  assign tbl_col   = col_q;
  assign res_valid = vld_q;
  assign res_code  = code_q;
  assign res_miss  = miss_q;
  assign res_hot   = rhot_q;

  // R4: a failed probe is followed by the next higher code
  p_scan_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_STEP && !hit && !last) |=> (tbl_col == VCODE_W'($past(tbl_col) + 1'b1)));

  // R5: a miss always reports the top code
  p_miss_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_code == CODE_MAX));

endmodule

// File: rtl/dvfs_spi_tx.sv
module dvfs_spi_tx
  import dvfs_vsel_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_st_e            st_q, st_d;
  logic              ph_q, ph_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bc_q, bc_d;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    sh_d = sh_q;
    bc_d = bc_q;
    case (st_q)
      TX_IDLE: begin
        if (start) begin
          st_d = TX_SHIFT;
          sh_d = data;
          bc_d = BIT_W'(DATA_W - 1);
          ph_d = 1'b0;
        end
      end
      default: begin
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (bc_q == '0) begin
            st_d = TX_IDLE;
          end else begin
            sh_d = sh_q << 1;
            bc_d = bc_q - 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
      ph_q <= 1'b0;
      sh_q <= '0;
      bc_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      sh_q <= sh_d;
      bc_q <= bc_d;
    end
  end

  assign busy = (st_q == TX_SHIFT);
  assign cs_n = (st_q != TX_SHIFT);
  assign sclk = (st_q == TX_SHIFT) && ph_q;
  assign mosi = sh_q[DATA_W-1];

  // R6: data settled before the rising serial clock and held through it
  p_mosi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  // R6: frame closes only right after a high serial-clock phase
  p_frame_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(sclk));

endmodule

// File: rtl/dvfs_vsel.sv
module dvfs_vsel #(
  parameter int TEMP_W      = 8,
  parameter int FREQ_W      = 8,
  parameter int VCODE_W     = 4,
  parameter int N_CORNER    = 4,
  parameter int TEMP_BASE   = 25,
  parameter int TEMP_STEP   = 20,
  parameter int HOLD_CYCLES = 32,
  parameter int CORNER_W    = (N_CORNER > 1) ? $clog2(N_CORNER) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TEMP_W-1:0]   temp,
  input  logic [FREQ_W-1:0]   freq_req,
  input  logic [FREQ_W-1:0]   tbl_fmax,
  output logic [CORNER_W-1:0] tbl_row,
  output logic [VCODE_W-1:0]  tbl_col,
  output logic [VCODE_W-1:0]  vcode,
  output logic                oor,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi
);

  localparam int                 HOLD_W   = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0]  HOLD_END = HOLD_W'(HOLD_CYCLES);
  localparam logic [VCODE_W-1:0] CODE_MAX = '1;

  logic [CORNER_W-1:0] corner;
  logic                hot;
  logic                res_valid, res_miss, res_hot;
  logic [VCODE_W-1:0]  res_code;
  logic                tx_busy, take, hold_ok;
  logic [VCODE_W-1:0]  vcode_q, vcode_d;
  logic [HOLD_W-1:0]   hold_q, hold_d;
  logic                oor_q, oor_d;

  dvfs_corner_map #(
    .TEMP_W   (TEMP_W),
    .N_CORNER (N_CORNER),
    .TEMP_BASE(TEMP_BASE),
    .TEMP_STEP(TEMP_STEP),
    .CORNER_W (CORNER_W)
  ) u_map (
    .temp  (temp),
    .corner(corner),
    .hot   (hot)
  );

  dvfs_vscan #(
    .CORNER_W(CORNER_W),
    .VCODE_W (VCODE_W),
    .FREQ_W  (FREQ_W)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .corner_in(corner),
    .hot_in   (hot),
    .freq_in  (freq_req),
    .tbl_row  (tbl_row),
    .tbl_col  (tbl_col),
    .tbl_fmax (tbl_fmax),
    .res_valid(res_valid),
    .res_code (res_code),
    .res_miss (res_miss),
    .res_hot  (res_hot)
  );

  dvfs_spi_tx #(
    .DATA_W(VCODE_W)
  ) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .start(take),
    .data (res_code),
    .busy (tx_busy),
    .sclk (spi_sclk),
    .cs_n (spi_cs_n),
    .mosi (spi_mosi)
  );

  assign hold_ok = (hold_q == HOLD_END);
  assign take    = res_valid && (res_code != vcode_q) && hold_ok && !tx_busy;

  always_comb begin
    vcode_d = vcode_q;
    hold_d  = hold_q;
    oor_d   = oor_q;
    if (take) begin
      vcode_d = res_code;
      hold_d  = '0;
    end else if (!hold_ok) begin
      hold_d = hold_q + 1'b1;
    end
    if (res_valid) begin
      oor_d = res_miss || res_hot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcode_q <= CODE_MAX;
      hold_q  <= HOLD_END;
      oor_q   <= 1'b0;
    end else begin
      vcode_q <= vcode_d;
      hold_q  <= hold_d;
      oor_q   <= oor_d;
    end
  end

  assign vcode = vcode_q;
  assign oor   = oor_q;

  // R8: a code change only after the hold window has run out
  p_hold_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcode_q) |-> $past(hold_ok));

  // R7: a frame opens only together with a code change
  p_frame_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !$stable(vcode_q));

  // R6: the new code equals the search result that caused it
  p_code_from_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcode_q) |-> (vcode_q == $past(res_code)));

  // R5: a failed search raises the flag
  p_oor_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |=> oor_q);

endmodule

// File: tb/dvfs_vsel_test.sv
module dvfs_vsel_test;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 32;
  localparam int SETTLE     = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] temp, freq_req, tbl_fmax;
  logic [1:0] tbl_row;
  logic [3:0] tbl_col, vcode;
  logic       oor, spi_sclk, spi_cs_n, spi_mosi;
  int         tvar;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int tbl_val(int v, int row, int col);
    int x;
    x = col * 16 + 10 - row * 12;
    if (v == 1 && col == 3) x = 255;
    if (x < 0) x = 0;
    if (x > 255) x = 255;
    return x;
  endfunction

  assign tbl_fmax = 8'(tbl_val(tvar, int'(tbl_row), int'(tbl_col)));

  dvfs_vsel uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .temp    (temp),
    .freq_req(freq_req),
    .tbl_fmax(tbl_fmax),
    .tbl_row (tbl_row),
    .tbl_col (tbl_col),
    .vcode   (vcode),
    .oor     (oor),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi)
  );

  // pin-level frame decoder, sampled on the falling clock edge
  int         cyc = 0;
  int         frames = 0, bad_frames = 0, nb = 0;
  int         last_fall = 0, min_gap = 1000000000, falls = 0;
  logic [3:0] sh = '0, last_frame = '0;
  logic       p_sclk = 1'b0, p_cs = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!spi_cs_n && p_cs) begin
        nb = 0;
        if (falls > 0 && (cyc - last_fall) < min_gap) min_gap = cyc - last_fall;
        last_fall = cyc;
        falls++;
      end
      if (!spi_cs_n && spi_sclk && !p_sclk) begin
        sh = {sh[2:0], spi_mosi};
        nb++;
      end
      if (spi_cs_n && !p_cs) begin
        if (nb == 4) begin
          last_frame = sh;
          frames++;
        end else begin
          bad_frames++;
        end
      end
    end
    p_sclk = spi_sclk;
    p_cs   = spi_cs_n;
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (temp=%0d freq=%0d table=%0d)",
               tag, act, exp, temp, freq_req, tvar);
    end
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_row(int t);
    for (int k = 0; k < 4; k++) if (t <= 25 + 20 * k) return k;
    return 3;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int temps[10] = '{0, 25, 26, 45, 46, 65, 66, 85, 86, 200};

  initial begin
    int prev_code, prev_oor, fr0, ecode, eoor, row;
    bit miss;
    string tag;
    rst_n    = 1'b0;
    temp     = 8'd25;
    freq_req = 8'd0;
    tvar     = 0;
    wait_cycles(3);
    // R1: reset state
    check("R1 vcode", int'(vcode), 15);
    check("R1 oor", int'(oor), 0);
    check("R1 cs_n", int'(spi_cs_n), 1);
    check("R1 sclk", int'(spi_sclk), 0);
    rst_n = 1'b1;
    wait_cycles(SETTLE);
    prev_code = 0;
    prev_oor  = 0;
    check("R4 first", int'(vcode), 0);

    for (int v = 0; v < 2; v++) begin
      for (int ti = 0; ti < 10; ti++) begin
        for (int f = 0; f <= 255; f += 15) begin
          tvar     = v;
          temp     = 8'(temps[ti]);
          freq_req = 8'(f);
          row      = exp_row(temps[ti]);
          ecode    = 15;
          miss     = 1'b1;
          for (int c = 0; c < 16; c++) begin
            if (miss && tbl_val(v, row, c) >= f) begin
              ecode = c;
              miss  = 1'b0;
            end
          end
          eoor = (miss || temps[ti] > 85) ? 1 : 0;
          fr0  = frames;
          wait_cycles(SETTLE);
          tag = (temps[ti] > 85) ? "R3 code" : (miss ? "R5 code" : "R2/R4 code");
          check(tag, int'(vcode), ecode);
          tag = (prev_oor == 1 && eoor == 0) ? "R9 oor" : (temps[ti] > 85 ? "R3 oor" : "R5 oor");
          check(tag, int'(oor), eoor);
          if (ecode == prev_code) check("R7 no frame", frames, fr0);
          else check("R6 frame content", int'(last_frame), ecode);
          prev_code = ecode;
          prev_oor  = eoor;
        end
      end
    end

    // R8: rapidly toggling demand must not change the code faster than the hold
    tvar      = 0;
    temp      = 8'd25;
    falls     = 0;
    min_gap   = 1000000000;
    for (int i = 0; i < 140; i++) begin
      freq_req = (i % 2 == 0) ? 8'd0 : 8'd255;
      wait_cycles(3);
    end
    check("R8 changes seen", (falls >= 2) ? 1 : 0, 1);
    check("R8 min gap", (min_gap >= HOLD) ? 1 : 0, 1);
    freq_req = 8'd100;
    wait_cycles(SETTLE);
    check("R4 after burst", int'(vcode), 6);
    check("R6 after burst", int'(last_frame), 6);
    check("R6 frame length", bad_frames, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule